// File: doc/BRIEF.md
# Receive Scatter-Gather Descriptor Filler

This block takes packets arriving as a byte stream (valid/ready handshake, a last-byte flag and five application sideband words) and stores them into memory. The buffers are described by a linked chain of receive descriptors. For each descriptor it reads the chain link, the buffer base and the buffer capacity. It then packs the incoming bytes into little-endian 32-bit words and writes them into the buffer. When it has finished with the descriptor, it writes back a status word marking the descriptor as used. A packet longer than one buffer spills into the following descriptors of the chain.

The channel is started by a one-cycle kick while the run input is high, which loads the first descriptor address. The filler stops and reports idle in two cases: when it fetches a descriptor that software has not yet recycled (completion flag still set), or when it has written back the descriptor at the tail address. The descriptor that receives a packet's last byte also gets the five application words, and the block pulses a packet-complete output to the interrupt logic.

Descriptor layout, in byte offsets from the descriptor base:

| Offset | Content |
|---|---|
| 0x00 | Next-descriptor pointer |
| 0x04 | Buffer base (word aligned) |
| 0x08 | Control word: bits 22:0 hold the capacity in bytes |
| 0x0C | Status word |
| 0x10 to 0x20 | Application words 0 to 4 |

Top module: `rxsg_filler`

## Requirements
- R1: A fetch reads four words at offsets 0x0, 0x4, 0x8 and 0xC of the descriptor. These give the next pointer, the buffer base, the capacity (control bits 22:0) and the status.
- R2: If a fetched status word has bit 31 set, the filler goes idle and accepts no stream bytes. It also writes nothing to that descriptor.
- R3: A descriptor receives at most its capacity in bytes. The remaining bytes of the packet go into the next descriptor of the chain.
- R4: Status bit 27 (start of frame) is set only in the first descriptor a packet uses. This holds for a packet that follows another packet in the chain.
- R5: The descriptor holding a packet's final byte gets status bit 26 (end of frame). The five application words are written at offsets 0x10 to 0x20 of that descriptor, and pktDone pulses for exactly one cycle.
- R6: Every descriptor used is written back at offset 0xC. The status word has bit 31 set and bits 22:0 equal to the number of bytes stored in it.
- R7: After a write-back, the filler goes idle if that descriptor was at the tail address. Otherwise it fetches the descriptor named by the next pointer.
- R8: Stream bytes are accepted only while run is high and the filler is not idle. A kick is honoured only while run is high.
- R9: Bytes are stored little-endian: byte n of a buffer goes into lane n mod 4 of the word at buffer base + 4*(n div 4). A partial word is written with only its filled byte enables set, so the bytes that follow it in memory are left unchanged.
- R10: sReady is low while any memory access is pending. memReq stays high until memAck.
- R11: After reset, idle is high and sReady, memReq and pktDone are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| run | input | 1 | Channel enable |
| kick | input | 1 | Start pulse; loads startPtr |
| startPtr | input | 32 | First descriptor address |
| tailPtr | input | 32 | Tail descriptor address |
| sData | input | 8 | Stream byte |
| sValid | input | 1 | Stream byte valid |
| sLast | input | 1 | Final byte of packet |
| sApp | input | 160 | Five application words, sampled with the last byte |
| sReady | output | 1 | Stream byte accepted when high with sValid |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Access is a write |
| memAddr | output | 32 | Byte address (word aligned) |
| memWdata | output | 32 | Write data |
| memBe | output | 4 | Byte enables for writes |
| memAck | input | 1 | Access completes this cycle |
| memRdata | input | 32 | Read data, valid with memAck |
| pktDone | output | 1 | One-cycle packet-complete pulse |
| idle | output | 1 | Filler is stopped |

## Verification
On every cycle, the assertions check the handshake rules. sReady never overlaps a memory access, a request is held until its acknowledge, and an idle filler refuses bytes. They also check that a byte is taken only while the descriptor has room, that a buffer flush always carries at least one byte enable, and that pktDone is a single pulse. Only the bench scenarios can show the memory image: how the bytes are spread across buffers of mixed capacity, the start- and end-of-frame bits over one or two packets, the application words, and where the chain walk halts at the tail or at an owned descriptor.

// File: rtl/rxsg_pkg.sv
package rxsg_pkg;
  typedef enum logic [2:0] {
    ST_HALT, ST_FETCH, ST_FILL, ST_FLUSH, ST_APP, ST_STAT
  } fillState_t;

  typedef struct packed {
    fillState_t state;
    logic [2:0] step;
    logic start;
    logic fetchAck;
    logic descGo;
    logic take;
    logic flushAck;
    logic statAck;
  } ctlStrobe_t;
endpackage

// File: rtl/rxsg_datapath.sv
module rxsg_datapath
  import rxsg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 23,
  parameter int APP_N  = 5
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctlStrobe_t            ctl,
  input  logic [ADDR_W-1:0]     startPtr,
  input  logic [ADDR_W-1:0]     tailPtr,
  input  logic [7:0]            sData,
  input  logic                  sLast,
  input  logic [APP_N*32-1:0]   sApp,
  input  logic [31:0]           memRdata,
  output logic [ADDR_W-1:0]     memAddr,
  output logic [31:0]           memWdata,
  output logic [3:0]            memBe,
  output logic                  memWe,
  output logic                  capFull,
  output logic                  accFull,
  output logic                  accAny,
  output logic                  eofSeen,
  output logic                  atTail
);
  localparam int APP_BASE = 16;
  localparam int STAT_OFF = 12;

  logic [ADDR_W-1:0]   curPtr, nextPtr, bufPtr, wordOff;
  logic [LEN_W-1:0]    capLen, byteCnt;
  logic [31:0]         acc;
  logic [3:0]          accBe;
  logic [1:0]          lane;
  logic [APP_N*32-1:0] appReg;
  logic                sofThis, midPkt;
  logic [ADDR_W-1:0]   stepOff;
  logic [31:0]         statWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curPtr <= '0; nextPtr <= '0; bufPtr <= '0; capLen <= '0;
      byteCnt <= '0; wordOff <= '0; acc <= '0; accBe <= '0; lane <= '0;
      eofSeen <= 1'b0; appReg <= '0; sofThis <= 1'b0; midPkt <= 1'b0;
    end else begin
      if (ctl.start) begin
        curPtr <= startPtr;
        midPkt <= 1'b0;
      end
      if (ctl.fetchAck) begin
        case (ctl.step)
          3'd0:    nextPtr <= memRdata[ADDR_W-1:0];
          3'd1:    bufPtr  <= memRdata[ADDR_W-1:0];
          3'd2:    capLen  <= memRdata[LEN_W-1:0];
          default: ;
        endcase
      end
      if (ctl.descGo) begin
        byteCnt <= '0; wordOff <= '0; acc <= '0; accBe <= '0; lane <= '0;
        eofSeen <= 1'b0;
        sofThis <= !midPkt;
      end
      if (ctl.take) begin
        acc[lane*8 +: 8] <= sData;
        accBe[lane]      <= 1'b1;
        lane             <= lane + 2'd1;
        byteCnt          <= byteCnt + 1'b1;
        if (sLast) begin
          eofSeen <= 1'b1;
          appReg  <= sApp;
        end
      end
      if (ctl.flushAck) begin
        acc     <= '0;
        accBe   <= '0;
        lane    <= '0;
        wordOff <= wordOff + ADDR_W'(4);
      end
      if (ctl.statAck) begin
        midPkt <= !eofSeen;
        if (!atTail) curPtr <= nextPtr;
      end
    end
  end

  assign capFull = (byteCnt == capLen);
  assign accFull = &accBe;
  assign accAny  = |accBe;
  assign atTail  = (curPtr == tailPtr);
  assign stepOff = {{(ADDR_W-5){1'b0}}, ctl.step, 2'b00};

  always_comb begin
    statWord              = '0;
    statWord[31]          = 1'b1;
    statWord[27]          = sofThis;
    statWord[26]          = eofSeen;
    statWord[LEN_W-1:0]   = byteCnt;
  end

  always_comb begin
    memAddr  = '0;
    memWdata = '0;
    memBe    = 4'hF;
    memWe    = 1'b0;
    case (ctl.state)
      ST_FETCH: memAddr = curPtr + stepOff;
      ST_FLUSH: begin
        memAddr  = bufPtr + wordOff;
        memWdata = acc;
        memBe    = accBe;
        memWe    = 1'b1;
      end
      ST_APP: begin
        memAddr  = curPtr + ADDR_W'(APP_BASE) + stepOff;
        memWdata = appReg[ctl.step*32 +: 32];
        memWe    = 1'b1;
      end
      ST_STAT: begin
        memAddr  = curPtr + ADDR_W'(STAT_OFF);
        memWdata = statWord;
        memWe    = 1'b1;
      end
      default: ;
    endcase
  end

  AST_TAKE_ROOM: assert property (@(posedge clk) disable iff (!rstN)
    ctl.take |-> byteCnt < capLen);  // R3
  AST_FLUSH_BYTES: assert property (@(posedge clk) disable iff (!rstN)
    ctl.state == ST_FLUSH |-> accBe != 4'h0);  // R9
endmodule

// File: rtl/rxsg_ctrl.sv
module rxsg_ctrl
  import rxsg_pkg::*;
#(
  parameter int APP_N = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       run,
  input  logic       kick,
  input  logic       sValid,
  input  logic       memAck,
  input  logic       ownedBit,
  input  logic       capFull,
  input  logic       accFull,
  input  logic       accAny,
  input  logic       eofSeen,
  input  logic       atTail,
  output ctlStrobe_t ctl,
  output logic       memReq,
  output logic       sReady,
  output logic       pktDone,
  output logic       idle
);
  localparam logic [2:0] FETCH_LAST = 3'd3;
  localparam logic [2:0] APP_LAST   = 3'(APP_N - 1);

  fillState_t state, stateNxt;
  logic [2:0] step, stepNxt;

  assign sReady = (state == ST_FILL) && run && !capFull && !eofSeen && !accFull;
  assign memReq = (state == ST_FETCH) || (state == ST_FLUSH) ||
                  (state == ST_APP)   || (state == ST_STAT);
  assign idle   = (state == ST_HALT);

  always_comb begin
    stateNxt     = state;
    stepNxt      = step;
    ctl          = '0;
    ctl.state    = state;
    ctl.step     = step;
    ctl.take     = sReady && sValid;
    case (state)
      ST_HALT:
        if (kick && run) begin
          ctl.start = 1'b1;
          stepNxt   = '0;
          stateNxt  = ST_FETCH;
        end
      ST_FETCH:
        if (memAck) begin
          ctl.fetchAck = 1'b1;
          stepNxt      = step + 3'd1;
          if (step == FETCH_LAST) begin
            stepNxt = '0;
            if (ownedBit) stateNxt = ST_HALT;
            else begin
              ctl.descGo = 1'b1;
              stateNxt   = ST_FILL;
            end
          end
        end
      ST_FILL:
        if (accFull || (accAny && (eofSeen || capFull))) stateNxt = ST_FLUSH;
        else if (eofSeen)                                stateNxt = ST_APP;
        else if (capFull)                                stateNxt = ST_STAT;
      ST_FLUSH:
        if (memAck) begin
          ctl.flushAck = 1'b1;
          stateNxt     = ST_FILL;
        end
      ST_APP:
        if (memAck) begin
          stepNxt = step + 3'd1;
          if (step == APP_LAST) begin
            stepNxt  = '0;
            stateNxt = ST_STAT;
          end
        end
      ST_STAT:
        if (memAck) begin
          ctl.statAck = 1'b1;
          stateNxt    = atTail ? ST_HALT : ST_FETCH;
        end
      default: stateNxt = ST_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_HALT;
      step    <= '0;
      pktDone <= 1'b0;
    end else begin
      state   <= stateNxt;
      step    <= stepNxt;
      pktDone <= ctl.statAck && eofSeen;
    end
  end

  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    sReady |-> !memReq);  // R10
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq);  // R10
  AST_IDLE_DEAF: assert property (@(posedge clk) disable iff (!rstN)
    idle |-> !sReady);  // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    pktDone |=> !pktDone);  // R5
endmodule

// File: rtl/rxsg_filler.sv
module rxsg_filler
  import rxsg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 23,
  parameter int APP_N  = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                run,
  input  logic                kick,
  input  logic [ADDR_W-1:0]   startPtr,
  input  logic [ADDR_W-1:0]   tailPtr,
  input  logic [7:0]          sData,
  input  logic                sValid,
  input  logic                sLast,
  input  logic [APP_N*32-1:0] sApp,
  output logic                sReady,
  output logic                memReq,
  output logic                memWe,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [31:0]         memWdata,
  output logic [3:0]          memBe,
  input  logic                memAck,
  input  logic [31:0]         memRdata,
  output logic                pktDone,
  output logic                idle
);
  ctlStrobe_t ctl;
  logic capFull, accFull, accAny, eofSeen, atTail;

  rxsg_ctrl #(.APP_N(APP_N)) ctrl_i (
    .clk(clk), .rstN(rstN), .run(run), .kick(kick), .sValid(sValid),
    .memAck(memAck), .ownedBit(memRdata[31]), .capFull(capFull),
    .accFull(accFull), .accAny(accAny), .eofSeen(eofSeen), .atTail(atTail),
    .ctl(ctl), .memReq(memReq), .sReady(sReady), .pktDone(pktDone),
    .idle(idle)
  );

  rxsg_datapath #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .APP_N(APP_N)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .startPtr(startPtr),
    .tailPtr(tailPtr), .sData(sData), .sLast(sLast), .sApp(sApp),
    .memRdata(memRdata), .memAddr(memAddr), .memWdata(memWdata),
    .memBe(memBe), .memWe(memWe), .capFull(capFull), .accFull(accFull),
    .accAny(accAny), .eofSeen(eofSeen), .atTail(atTail)
  );
endmodule

// File: tb/rxsg_filler_tb.sv
module rxsg_filler_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic run = 1'b0, kick = 1'b0;
  logic [31:0] startPtr = '0, tailPtr = '0;
  logic [7:0] sData = '0;
  logic sValid = 1'b0, sLast = 1'b0;
  logic [159:0] sApp = '0;
  logic sReady, memReq, memWe, pktDone, idle;
  logic [31:0] memAddr, memWdata;
  logic [3:0] memBe;
  logic memAck = 1'b0;
  logic [31:0] memRdata = '0;

  logic [7:0] mem [0:511];
  int checks = 0, failures = 0, overlap = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  rxsg_filler dut_i (
    .clk(clk), .rstN(rstN), .run(run), .kick(kick), .startPtr(startPtr),
    .tailPtr(tailPtr), .sData(sData), .sValid(sValid), .sLast(sLast),
    .sApp(sApp), .sReady(sReady), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memBe(memBe), .memAck(memAck),
    .memRdata(memRdata), .pktDone(pktDone), .idle(idle)
  );

  always @(posedge clk) begin
    if (!rstN) memAck <= 1'b0;
    else if (memReq && !memAck) begin
      memAck <= 1'b1;
      if (memWe) begin
        for (int b = 0; b < 4; b++)
          if (memBe[b]) mem[memAddr[8:0] + 9'(b)] <= memWdata[b*8 +: 8];
      end else
        memRdata <= {mem[memAddr[8:0]+9'd3], mem[memAddr[8:0]+9'd2],
                     mem[memAddr[8:0]+9'd1], mem[memAddr[8:0]]};
    end else memAck <= 1'b0;
  end

  always @(negedge clk) if (sReady && memReq) overlap++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rdW(input int a);
    return {mem[a+3], mem[a+2], mem[a+1], mem[a]};
  endfunction

  task automatic wrW(input int a, input logic [31:0] v);
    for (int b = 0; b < 4; b++) mem[a+b] = v[b*8 +: 8];
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0; run = 1'b0; kick = 1'b0; sValid = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic buildChain(input int c0, input int c1, input int c2);
    for (int i = 0; i < 512; i++) mem[i] = (i >= 256) ? 8'hEE : 8'h00;
    wrW(32'h000, 32'h040); wrW(32'h004, 32'h100); wrW(32'h008, c0);
    wrW(32'h040, 32'h080); wrW(32'h044, 32'h140); wrW(32'h048, c1);
    wrW(32'h080, 32'h000); wrW(32'h084, 32'h180); wrW(32'h088, c2);
  endtask

  task automatic doKick();
    @(negedge clk); startPtr = 32'h0; tailPtr = 32'h080; kick = 1'b1;
    @(negedge clk); kick = 1'b0;
  endtask

  task automatic sendPkt(input int len, input int base);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      sValid = 1'b1; sData = 8'(base + i); sLast = (i == len - 1);
      for (int k = 0; k < 5; k++) sApp[k*32 +: 32] = 32'hA500_0000 + 32'(len * 16 + k);
      while (!sReady) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk); sValid = 1'b0; sLast = 1'b0;
  endtask

  task automatic waitDone();
    bit seen = 0;
    for (int i = 0; i < 400 && !seen; i++) begin
      @(negedge clk);
      if (pktDone) seen = 1;
    end
    chk("R5 pktDone pulse", 32'(seen), 32'd1);
  endtask

  localparam int VEC_N = 6;
  // packed as len, cap0, cap1, cap2
  localparam logic [31:0] VECS [0:VEC_N-1] = '{
    32'h05_10_10_10, 32'h08_04_04_04, 32'h0A_04_04_04,
    32'h01_08_08_08, 32'h07_03_02_08, 32'h0C_0C_04_04
  };

  initial begin
    for (int w = 0; w < 150000 && !finished; w++) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = 8'h00;
    doReset();
    @(negedge clk);
    chk("R11 idle", 32'(idle), 32'd1);
    chk("R11 sReady", 32'(sReady), 32'd0);
    chk("R11 memReq", 32'(memReq), 32'd0);
    chk("R11 pktDone", 32'(pktDone), 32'd0);

    // vector table
    for (int v = 0; v < VEC_N; v++) begin
      int len, rem, base, lastIdx;
      int caps [3];
      len = int'(VECS[v][31:24]);
      caps[0] = int'(VECS[v][23:16]); caps[1] = int'(VECS[v][15:8]); caps[2] = int'(VECS[v][7:0]);
      base = 8'h30 + len;
      doReset();
      buildChain(caps[0], caps[1], caps[2]);
      run = 1'b1;
      doKick();
      sendPkt(len, base);
      waitDone();
      repeat (12) @(negedge clk);
      rem = len; lastIdx = 0;
      for (int k = 0; k < 3; k++) begin
        int n, da, ba;
        da = k * 64; ba = 256 + k * 64;
        if (rem == 0) begin
          chk("R3 unused descriptor status", rdW(da + 12), 32'h0);
          continue;
        end
        n = (caps[k] < rem) ? caps[k] : rem;
        rem -= n;
        lastIdx = k;
        chk("R6 R4 R3 status word", rdW(da + 12),
            32'h8000_0000 | ((k == 0) ? 32'h0800_0000 : 0) |
            ((rem == 0) ? 32'h0400_0000 : 0) | 32'(n));
        for (int b = 0; b < n; b++)
          chk("R1 R9 buffer byte", 32'(mem[ba + b]), 32'(8'(base + len - rem - n + b)));
        chk("R9 byte past fill untouched", 32'(mem[ba + n]), 32'hEE);
        if (rem == 0)
          for (int a = 0; a < 5; a++)
            chk("R5 app word", rdW(da + 16 + 4 * a), 32'hA500_0000 + 32'(len * 16 + a));
      end
      chk("R7 idle after walk", 32'(idle), (lastIdx == 2) ? 32'd1 : 32'd0);
    end

    // two packets back to back
    doReset();
    buildChain(8, 8, 8);
    run = 1'b1;
    doKick();
    sendPkt(3, 8'h10); waitDone();
    sendPkt(6, 8'h60); waitDone();
    repeat (12) @(negedge clk);
    chk("R4 first packet status", rdW(12), 32'h8C00_0003);
    chk("R4 second packet SOF", rdW(64 + 12), 32'h8C00_0006);
    chk("R7 next pointer followed", 32'(mem[320]), 32'h60);

    // owned descriptor halts the walk
    doReset();
    buildChain(8, 8, 8);
    wrW(12, 32'h8000_0000);
    run = 1'b1;
    doKick();
    sValid = 1'b1; sData = 8'h77; sLast = 1'b1;
    repeat (20) @(negedge clk);
    chk("R2 idle on owned", 32'(idle), 32'd1);
    chk("R2 no byte taken", 32'(sReady), 32'd0);
    chk("R2 status untouched", rdW(12), 32'h8000_0000);
    chk("R2 buffer untouched", 32'(mem[256]), 32'hEE);
    sValid = 1'b0; sLast = 1'b0;

    // not running: kick ignored
    doReset();
    buildChain(8, 8, 8);
    run = 1'b0;
    doKick();
    sValid = 1'b1;
    repeat (6) @(negedge clk);
    chk("R8 kick ignored idle", 32'(idle), 32'd1);
    chk("R8 no request", 32'(memReq), 32'd0);
    chk("R8 no ready", 32'(sReady), 32'd0);
    sValid = 1'b0;

    chk("R10 ready never with request", 32'(overlap), 32'd0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule